// File: doc/BRIEF.md
# Multi-channel trigger condition matcher

This block watches a parallel sample stream, one word per strobe, and emits a single-cycle trigger pulse when a programmed per-channel condition holds across all participating channels at once. Each channel carries three programming bits: mask, value and edge. Together they select one of six conditions: don't-care, level high, level low, rising edge, falling edge or any edge. A separate channel-enable word removes channels from the condition entirely. Edge conditions compare the current valid sample against the previous valid sample.

The matcher is controlled by a level arm input. While arm is low the block is idle and forgets its sample history. Raising arm starts a new attempt. The first valid sample that meets every condition produces one pulse. No further pulse appears until arm is dropped and raised again. The programming words are taken combinationally. The caller holds them steady while armed.

Top module: `trig_match_top`

## Requirements
- R1: After reset, trig_o is 0 and no previous sample is held, so edge conditions cannot match on the first sample.
- R2: A channel with mask=1 and edge=0 is a don't-care and never blocks the trigger.
- R3: A channel with mask=0 and edge=0 requires its sample bit to equal its value bit (1 = high, 0 = low).
- R4: A channel with mask=0 and edge=1 requires a transition from the previous valid sample that ends at its value bit (value=1 rising, value=0 falling).
- R5: A channel with mask=1 and edge=1 requires any change from the previous valid sample.
- R6: A channel whose enable bit is 0 is excluded from the condition, whatever its mask, value and edge bits.
- R7: Edges are judged only against the previous valid sample taken while armed; cycles with the strobe low neither match nor update the history, and no edge matches on the first valid sample after arming.
- R8: At most one pulse is produced per arm period; dropping arm_i for at least one cycle and raising it again re-arms, and nothing fires while arm_i is low.
- R9: The trigger fires only when all enabled channels meet their conditions on the same valid sample; with no channel constrained it fires on the first valid sample after arming.
- R10: trig_o is high for exactly one cycle, the cycle after the clock edge that accepted the matching sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Level arm; low clears history and re-enables firing |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | N_CH | Sample word |
| mask_i | input | N_CH | Per-channel mask bits |
| value_i | input | N_CH | Per-channel value bits |
| edge_i | input | N_CH | Per-channel edge bits |
| chen_i | input | N_CH | Per-channel enable bits |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
On a two-channel instance the bench sweeps every per-channel code, including enable, against every previous/current sample pair. It checks the pulse on both the first and the second sample after arming, so a design that lets an edge match against stale or reset history fires one vector early. A design that lets a disabled or don't-care channel block the condition stays silent where a pulse is due. Directed runs insert invalid-strobe gaps carrying different data, which exposes a history register that loads on every cycle. Long armed windows catch a matcher that re-fires while its condition still holds. Re-arming checks that dropping arm really restores firing.

// File: rtl/trig_match_pkg.sv
package trig_match_pkg;

  // Condition class selected by {mask, edge}
  typedef enum logic [1:0] {
    COND_LEVEL    = 2'b00,
    COND_DIR_EDGE = 2'b01,
    COND_IGNORE   = 2'b10,
    COND_ANY_EDGE = 2'b11
  } cond_kind_t;

  typedef struct packed {
    logic en;
    logic mask;
    logic value;
    logic edg;
  } ch_cfg_t;

endpackage

// File: rtl/trig_match_cell.sv
module trig_match_cell
  import trig_match_pkg::*;
(
  input  ch_cfg_t cfg_i,
  input  logic    cur_i,
  input  logic    prev_i,
  input  logic    have_prev_i,
  output logic    ok_o
);

  cond_kind_t kind;
  logic       moved;

  assign kind  = cond_kind_t'({cfg_i.mask, cfg_i.edg});
  assign moved = have_prev_i & (cur_i ^ prev_i);

  always_comb begin
    ok_o = 1'b1;
    if (cfg_i.en) begin
      unique case (kind)
        COND_LEVEL:    ok_o = (cur_i == cfg_i.value);
        COND_DIR_EDGE: ok_o = moved & (cur_i == cfg_i.value);
        COND_IGNORE:   ok_o = 1'b1;
        COND_ANY_EDGE: ok_o = moved;
        default:       ok_o = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/trig_match_hist.sv
module trig_match_hist #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] smp_i,
  output logic [W-1:0] prev_o,
  output logic         have_prev_o
);

  logic [W-1:0] prev_d, prev_q;
  logic         have_d, have_q;

  always_comb begin
    prev_d = prev_q;
    have_d = have_q;
    if (clr_i) begin
      have_d = 1'b0;
    end else if (load_i) begin
      prev_d = smp_i;
      have_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      have_q <= have_d;
    end
  end

  assign prev_o      = prev_q;
  assign have_prev_o = have_q;

  // R7
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !load_i) |=> ($stable(prev_q) && $stable(have_q)));

  // R1
  hist_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !have_q);

endmodule

// File: rtl/trig_match_top.sv
module trig_match_top
  import trig_match_pkg::*;
#(
  parameter int N_CH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm_i,
  input  logic            smp_vld_i,
  input  logic [N_CH-1:0] smp_i,
  input  logic [N_CH-1:0] mask_i,
  input  logic [N_CH-1:0] value_i,
  input  logic [N_CH-1:0] edge_i,
  input  logic [N_CH-1:0] chen_i,
  output logic            trig_o
);

  logic [N_CH-1:0] prev;
  logic            have_prev;
  logic [N_CH-1:0] ch_ok;
  logic            accept;
  logic            hit;
  logic            fire_d;
  logic            done_d, done_q;
  logic            trig_q;

  assign accept = arm_i & smp_vld_i;

  trig_match_hist #(.W(N_CH)) hist_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (~arm_i),
    .load_i      (accept),
    .smp_i       (smp_i),
    .prev_o      (prev),
    .have_prev_o (have_prev)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    ch_cfg_t cfg;
    assign cfg.en    = chen_i[k];
    assign cfg.mask  = mask_i[k];
    assign cfg.value = value_i[k];
    assign cfg.edg   = edge_i[k];

    trig_match_cell cell_i (
      .cfg_i       (cfg),
      .cur_i       (smp_i[k]),
      .prev_i      (prev[k]),
      .have_prev_i (have_prev),
      .ok_o        (ch_ok[k])
    );

    // R7
    first_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !have_prev && chen_i[k] && edge_i[k]) |-> !ch_ok[k]);
  end

  assign hit = &ch_ok;

  always_comb begin
    fire_d = accept & hit & ~done_q;
    done_d = arm_i & (done_q | fire_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      done_q <= done_d;
      trig_q <= fire_d;
    end
  end

  assign trig_o = trig_q;

  // R10
  one_cycle_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

  // R10
  trig_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> $past(arm_i && smp_vld_i));

  // R8
  no_trig_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> !trig_o);

  // R8
  once_per_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o && arm_i) |=> (!trig_o && done_q));

endmodule

// File: tb/trig_match_top_tb_top.sv
module trig_match_top_tb_top;

  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          arm_i, smp_vld_i;
  logic [NC-1:0] smp_i, mask_i, value_i, edge_i, chen_i;
  logic          trig_o;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  trig_match_top #(.N_CH(NC)) dut_i (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .smp_vld_i(smp_vld_i),
    .smp_i(smp_i), .mask_i(mask_i), .value_i(value_i), .edge_i(edge_i),
    .chen_i(chen_i), .trig_o(trig_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s trig_o=%0b expected=%0b (m=%b v=%b e=%b en=%b s=%b)",
               req, act, exp, mask_i, value_i, edge_i, chen_i, smp_i);
    end
  endtask

  // drive at negedge, look 1 ns after the following posedge
  task automatic cyc(input logic arm, input logic vld, input logic [NC-1:0] s);
    @(negedge clk);
    arm_i = arm; smp_vld_i = vld; smp_i = s;
    @(posedge clk);
    #1;
  endtask

  function automatic logic model(input logic [NC-1:0] m, v, e, en,
                                 input logic have, input logic [NC-1:0] p, c);
    logic all_ok = 1'b1;
    for (int k = 0; k < NC; k++) begin
      logic ok;
      if (!en[k]) continue;
      case ({m[k], e[k]})
        2'b10:   ok = 1'b1;
        2'b00:   ok = (c[k] == v[k]);
        2'b01:   ok = have && (p[k] != c[k]) && (c[k] == v[k]);
        default: ok = have && (p[k] != c[k]);
      endcase
      all_ok &= ok;
    end
    return all_ok;
  endfunction

  task automatic set_cfg(input logic [NC-1:0] m, v, e, en);
    @(negedge clk);
    mask_i = m; value_i = v; edge_i = e; chen_i = en;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; arm_i = 1'b0; smp_vld_i = 1'b0; smp_i = '0;
    mask_i = '1; value_i = '0; edge_i = '0; chen_i = '1;
    repeat (3) @(posedge clk);
    #1 chk("R1 reset", trig_o, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    // R1: unconstrained-but-edge after reset: first sample cannot match an edge
    set_cfg(2'b11, 2'b00, 2'b11, 2'b11);
    cyc(1'b1, 1'b1, 2'b11);
    chk("R1 first edge after reset", trig_o, 1'b0);
    cyc(1'b0, 1'b0, 2'b00);

    // Exhaustive sweep: R2 R3 R4 R5 R6 R7 R9 R10
    for (int cfg = 0; cfg < 256; cfg++) begin
      logic [NC-1:0] m, v, e, en;
      for (int k = 0; k < NC; k++) begin
        m[k]  = cfg[4*k];
        v[k]  = cfg[4*k+1];
        e[k]  = cfg[4*k+2];
        en[k] = cfg[4*k+3];
      end
      set_cfg(m, v, e, en);
      for (int p = 0; p < 4; p++) begin
        for (int c = 0; c < 4; c++) begin
          logic e1, e2;
          e1 = model(m, v, e, en, 1'b0, '0, p[NC-1:0]);
          e2 = model(m, v, e, en, 1'b1, p[NC-1:0], c[NC-1:0]);
          cyc(1'b0, 1'b0, '0);
          cyc(1'b1, 1'b1, p[NC-1:0]);
          chk("R7 R9 first sample (R2 R3 R4 R5 R6)", trig_o, e1);
          cyc(1'b1, 1'b1, c[NC-1:0]);
          chk("R9 second sample (R2 R3 R4 R5 R6 R8)", trig_o, e2 & ~e1);
          cyc(1'b1, 1'b0, c[NC-1:0]);
          chk("R10 pulse width", trig_o, 1'b0);
        end
      end
    end

    // R7: invalid cycles neither match nor update history (ch0 rising)
    set_cfg(2'b10, 2'b01, 2'b01, 2'b11);
    cyc(1'b0, 1'b0, 2'b00);
    cyc(1'b1, 1'b1, 2'b00);
    chk("R7 base sample", trig_o, 1'b0);
    cyc(1'b1, 1'b0, 2'b01);
    chk("R7 invalid rising ignored", trig_o, 1'b0);
    cyc(1'b1, 1'b0, 2'b01);
    chk("R7 invalid hold", trig_o, 1'b0);
    cyc(1'b1, 1'b1, 2'b01);
    chk("R7 rise vs last valid", trig_o, 1'b1);
    // falling on ch0: an invalid low must not become history
    set_cfg(2'b10, 2'b00, 2'b01, 2'b11);
    cyc(1'b0, 1'b0, 2'b00);
    cyc(1'b1, 1'b1, 2'b01);
    cyc(1'b1, 1'b0, 2'b00);
    cyc(1'b1, 1'b1, 2'b00);
    chk("R7 fall vs last valid high", trig_o, 1'b1);

    // R8: held arm with always-true condition fires once only
    set_cfg(2'b11, 2'b00, 2'b00, 2'b11);
    cyc(1'b0, 1'b0, 2'b00);
    cyc(1'b1, 1'b1, 2'b10);
    chk("R9 unconstrained first sample", trig_o, 1'b1);
    for (int i = 0; i < 6; i++) begin
      cyc(1'b1, 1'b1, i[NC-1:0]);
      chk("R8 no refire while armed", trig_o, 1'b0);
    end
    cyc(1'b0, 1'b1, 2'b00);
    chk("R8 silent while disarmed", trig_o, 1'b0);
    cyc(1'b1, 1'b1, 2'b00);
    chk("R8 rearm fires again", trig_o, 1'b1);

    // R4 with both channels: rising ch0 and falling ch1 simultaneously
    set_cfg(2'b00, 2'b01, 2'b11, 2'b11);
    cyc(1'b0, 1'b0, 2'b00);
    cyc(1'b1, 1'b1, 2'b10);
    cyc(1'b1, 1'b1, 2'b00);
    chk("R4 only fall, no rise", trig_o, 1'b0);
    cyc(1'b1, 1'b1, 2'b10);
    cyc(1'b1, 1'b1, 2'b01);
    chk("R4 rise and fall together", trig_o, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule